// File: doc/BRIEF.md
# Slow-Domain Register Write Bridge

This block carries register writes from a fast bus clock into an always-on register domain that runs from a slow clock of about 32 kHz. It holds one write at a time in a capture register. A toggle handshake moves the write across the clock boundary. In the slow domain the write comes out as a single-cycle strobe with its address and data.

Software tracks progress through four flags in a status word: busy, ready-for-next, complete and error. Reading the status word clears the complete flag. If software writes again while the previous write is still in flight, the new write is dropped and the error flag is raised. Software clears the error flag with a write to the status address that has the error bit set. That clearing write is itself carried across the boundary.

Writes to the interrupt-enable address never cross the boundary. They take effect in the fast domain at once. An interrupt line combines the three flags, each one gated by its own enable bit.

Top module: `slow_wr_bridge`

## Requirements
- R1: After reset, status reads 0x0000_0200: only the ready-for-next bit 9 is set. The interrupt and the slow-domain strobe are low.
- R2: Conditions for acceptance: a write to any address other than the interrupt-enable address, while busy is clear. When such a write is accepted, from the next bus cycle busy (bit 10) reads 1 and ready-for-next (bit 9) reads 0. Both stay that way until the write completes.
- R3: An accepted write appears at the slow-domain port as a strobe that lasts exactly one slow cycle. It carries the captured address and data. It arrives 2 to 4 slow clock edges after acceptance.
- R4: When the slow domain has applied the write, busy clears, ready-for-next sets and complete (bit 8) sets.
- R5: A status read strobe clears complete in the following cycle. If a completion lands in the same cycle as the read, complete stays set.
- R6: A write that is not to the interrupt-enable address and arrives while busy is set is dropped and sets error (bit 7). The write already in flight is still delivered with its original address and data.
- R7: An accepted write to the status address with data bit 7 set clears error at the moment that write completes, not before. A status write with bit 7 clear leaves error unchanged.
- R8: A write to the interrupt-enable address takes effect in the next bus cycle. It never sets busy, complete or error, even when it arrives during busy. It never reaches the slow-domain port.
- R9: Interrupt-enable bits 9, 8 and 7 gate ready-for-next, complete and error respectively. The interrupt output is the OR of the enabled flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| slow_clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Bus write address |
| wr_data | input | DW | Bus write data |
| rd_stat | input | 1 | Status read strobe |
| status | output | DW | Status word: bit 10 busy, 9 ready-for-next, 8 complete, 7 error |
| irq | output | 1 | Combined interrupt |
| tgt_we | output | 1 | Slow-domain write strobe |
| tgt_addr | output | AW | Slow-domain write address |
| tgt_data | output | DW | Slow-domain write data |

## Verification
The assertions assume that the bus strobes are single-cycle and synchronous to the bus clock. They also assume that both clocks run, with the slow clock much slower than the bus clock. The bench drives all inputs on falling bus edges. It issues a second write only a few bus cycles after the first, well away from the completion edge, so a collision and a completion never fall in the same cycle. Status reads are issued only while the bridge is idle. This keeps the expected value of every flag unambiguous at each sampling point.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    localparam int BIT_ERR = 7;
    localparam int BIT_CPL = 8;
    localparam int BIT_NXT = 9;
    localparam int BIT_BSY = 10;

    typedef struct packed {
        logic nxt;
        logic cpl;
        logic err;
    } flag_en_t;
endpackage

// File: rtl/sdw_sync2.sv
module sdw_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/sdw_slow_apply.sv
module sdw_slow_apply #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          slow_clk,
    input  logic          rst_n,
    input  logic          req_sync,
    input  logic [AW-1:0] cap_addr,
    input  logic [DW-1:0] cap_data,
    output logic          tgt_we,
    output logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_data,
    output logic          ack_tog
);
    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          ack;
    } sl_t;

    sl_t s_q, s_d;

    always_comb begin
        s_d    = s_q;
        s_d.we = (req_sync != s_q.ack);
        if (req_sync != s_q.ack) begin
            s_d.addr = cap_addr;
            s_d.data = cap_data;
            s_d.ack  = req_sync;
        end
    end

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tgt_we   = s_q.we;
    assign tgt_addr = s_q.addr;
    assign tgt_data = s_q.data;
    assign ack_tog  = s_q.ack;

    AST_WE_SINGLE: assert property (@(posedge slow_clk) disable iff (!rst_n)
        tgt_we |=> !tgt_we); // R3
endmodule

// File: rtl/sdw_bus_ctl.sv
module sdw_bus_ctl
    import sdw_pkg::*;
#(
    parameter int          AW        = 6,
    parameter int          DW        = 32,
    parameter logic [AW-1:0] STAT_ADDR = 6'h04,
    parameter logic [AW-1:0] IER_ADDR  = 6'h08
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_stat,
    input  logic          ack_sync,
    output logic          req_tog,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_data,
    output logic [DW-1:0] status,
    output logic          irq
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          req;
        logic          ack_seen;
        logic          busy;
        logic          cpl;
        logic          err;
        logic          clr_pend;
        flag_en_t      ier;
    } bus_t;

    bus_t b_q, b_d;
    logic is_ier, is_sync, ack_edge;

    always_comb begin
        b_d      = b_q;
        is_ier   = wr_en && (wr_addr == IER_ADDR);
        is_sync  = wr_en && (wr_addr != IER_ADDR);
        ack_edge = (ack_sync != b_q.ack_seen);

        if (ack_edge) begin
            b_d.ack_seen = ack_sync;
            b_d.busy     = 1'b0;
            b_d.cpl      = 1'b1;
            b_d.clr_pend = 1'b0;
            if (b_q.clr_pend) b_d.err = 1'b0;
        end else if (rd_stat) begin
            b_d.cpl = 1'b0;
        end

        if (is_sync && b_q.busy) b_d.err = 1'b1;

        if (is_sync && !b_q.busy) begin
            b_d.addr     = wr_addr;
            b_d.data     = wr_data;
            b_d.req      = ~b_q.req;
            b_d.busy     = 1'b1;
            b_d.clr_pend = (wr_addr == STAT_ADDR) && wr_data[BIT_ERR];
        end

        if (is_ier) begin
            b_d.ier.nxt = wr_data[BIT_NXT];
            b_d.ier.cpl = wr_data[BIT_CPL];
            b_d.ier.err = wr_data[BIT_ERR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    always_comb begin
        status          = '0;
        status[BIT_BSY] = b_q.busy;
        status[BIT_NXT] = !b_q.busy;
        status[BIT_CPL] = b_q.cpl;
        status[BIT_ERR] = b_q.err;
    end

    assign irq      = (b_q.ier.nxt && !b_q.busy) || (b_q.ier.cpl && b_q.cpl) || (b_q.ier.err && b_q.err);
    assign req_tog  = b_q.req;
    assign cap_addr = b_q.addr;
    assign cap_data = b_q.data;

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr != IER_ADDR) && !status[BIT_BSY] |=> status[BIT_BSY] && !status[BIT_NXT]); // R2
    AST_COLLIDE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr != IER_ADDR) && status[BIT_BSY] |=> status[BIT_ERR]); // R6
    AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr != IER_ADDR) && status[BIT_BSY] |=> $stable(cap_data) && $stable(req_tog)); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat && !status[BIT_BSY] |=> !status[BIT_CPL]); // R5
    AST_IER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == IER_ADDR) && !status[BIT_BSY] |=> !status[BIT_BSY] && $stable(req_tog)); // R8
    AST_ERR_CLR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[BIT_ERR]) |-> $fell(status[BIT_BSY])); // R7
endmodule

// File: rtl/slow_wr_bridge.sv
module slow_wr_bridge #(
    parameter int            AW        = 6,
    parameter int            DW        = 32,
    parameter int            SYNC_STG  = 2,
    parameter logic [AW-1:0] STAT_ADDR = 6'h04,
    parameter logic [AW-1:0] IER_ADDR  = 6'h08
) (
    input  logic          clk,
    input  logic          slow_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_stat,
    output logic [DW-1:0] status,
    output logic          irq,
    output logic          tgt_we,
    output logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_data
);
    logic          req_tog, req_sync, ack_tog, ack_sync;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;

    sdw_bus_ctl #(.AW(AW), .DW(DW), .STAT_ADDR(STAT_ADDR), .IER_ADDR(IER_ADDR)) u_bus (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_stat(rd_stat), .ack_sync(ack_sync), .req_tog(req_tog), .cap_addr(cap_addr),
        .cap_data(cap_data), .status(status), .irq(irq)
    );

    sdw_sync2 #(.STAGES(SYNC_STG)) u_req_sync (
        .clk(slow_clk), .rst_n(rst_n), .d(req_tog), .q(req_sync)
    );

    sdw_sync2 #(.STAGES(SYNC_STG)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_tog), .q(ack_sync)
    );

    sdw_slow_apply #(.AW(AW), .DW(DW)) u_slow (
        .slow_clk(slow_clk), .rst_n(rst_n), .req_sync(req_sync), .cap_addr(cap_addr),
        .cap_data(cap_data), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
        .ack_tog(ack_tog)
    );
endmodule

// File: tb/tb_slow_wr_bridge.sv
`timescale 1ns/1ps
module tb_slow_wr_bridge;
    localparam logic [5:0] STAT = 6'h04;
    localparam logic [5:0] IER  = 6'h08;

    logic        clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_stat = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] status;
    logic        irq, tgt_we;
    logic [5:0]  tgt_addr;
    logic [31:0] tgt_data;

    slow_wr_bridge dut (
        .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_stat(rd_stat), .status(status), .irq(irq),
        .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
    );

    always #2.5 clk = ~clk;
    initial begin
        #1.1;
        forever #43.3 slow_clk = ~slow_clk;
    end

    int n_chk = 0, n_fail = 0, cyc = 0, slow_edges = 0, mark = 0;
    int head = 0, tail = 0;
    logic [5:0]  q_a [256];
    logic [31:0] q_d [256];
    int          q_m [256];
    logic        exp_err = 0, exp_cpl = 0, pend_clr = 0, inflight = 0;
    logic [2:0]  exp_ier = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic model_irq();
        return exp_ier[2] | (exp_ier[1] & exp_cpl) | (exp_ier[0] & exp_err);
    endfunction

    always @(posedge slow_clk) slow_edges <= slow_edges + 1;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL R4 watchdog actual=%0d expected=<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // slow-domain monitor: every strobe must match the oldest accepted write
    always @(negedge slow_clk) begin
        if (rst_n && tgt_we) begin
            if (head == tail) begin
                chk("R6 R8 unexpected strobe", 32'd1, 32'd0);
            end else begin
                chk("R3 addr", {26'd0, tgt_addr}, {26'd0, q_a[head % 256]});
                chk("R3 data", tgt_data, q_d[head % 256]);
                chk("R3 latency", 32'((slow_edges - q_m[head % 256]) >= 2 && (slow_edges - q_m[head % 256]) <= 4), 32'd1);
                head++;
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        logic was_busy;
        was_busy = status[10];
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        mark = slow_edges;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == IER) begin
            exp_ier = d[9:7];
            chk("R8 ier no error", {31'd0, status[7]}, {31'd0, exp_err});
            if (!was_busy) begin
                chk("R8 ier no busy", {30'd0, status[10:9]}, 32'd1);
                chk("R9 irq after ier", {31'd0, irq}, {31'd0, model_irq()});
            end
        end else if (was_busy) begin
            exp_err = 1'b1;
            chk("R6 error on collision", {31'd0, status[7]}, 32'd1);
        end else begin
            q_a[tail % 256] = a; q_d[tail % 256] = d; q_m[tail % 256] = mark; tail++;
            inflight = 1'b1;
            if (a == STAT && d[7]) pend_clr = 1'b1;
            chk("R2 busy set", {30'd0, status[10:9]}, 32'd2);
            chk("R7 error held until done", {31'd0, status[7]}, {31'd0, exp_err});
        end
    endtask

    task automatic idle();
        int w;
        w = 0;
        while ((status[10] || head != tail) && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk("R4 completes", 32'(w < 5000), 32'd1);
        if (inflight) begin exp_cpl = 1'b1; inflight = 1'b0; end
        if (pend_clr) begin exp_err = 1'b0; pend_clr = 1'b0; end
        chk("R4 idle flags", {30'd0, status[10:9]}, 32'd1);
        chk("R4 complete", {31'd0, status[8]}, {31'd0, exp_cpl});
        chk("R7 error state", {31'd0, status[7]}, {31'd0, exp_err});
        chk("R9 irq", {31'd0, irq}, {31'd0, model_irq()});
    endtask

    task automatic rd();
        rd_stat = 1'b1;
        @(negedge clk);
        rd_stat = 1'b0;
        exp_cpl = 1'b0;
        chk("R5 read clears complete", {31'd0, status[8]}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk("R1 reset status", status, 32'h0000_0200);
        chk("R1 reset irq", {31'd0, irq}, 32'd0);
        chk("R1 reset strobe", {31'd0, tgt_we}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        wr(6'h10, 32'hA5A5_0001);
        idle();
        rd();

        wr(6'h14, 32'h1111_2222);
        repeat (3) @(negedge clk);
        wr(6'h18, 32'hDEAD_BEEF);
        idle();

        wr(STAT, 32'h0000_0000);
        idle();
        wr(STAT, 32'h0000_0080);
        idle();

        wr(IER, 32'h0000_0380);
        wr(6'h20, 32'h0000_0055);
        wr(IER, 32'h0000_0100);
        idle();
        rd();
        chk("R9 irq after read", {31'd0, irq}, {31'd0, model_irq()});

        for (int i = 0; i < 150; i++) begin
            logic [5:0]  a;
            logic [31:0] d;
            int          sel;
            sel = int'($urandom % 5);
            a = (sel == 0) ? STAT : (sel == 1) ? IER : 6'(6'h10 + 6'($urandom % 40));
            d = $urandom;
            wr(a, d);
            if ($urandom % 3 == 0) begin
                repeat (1 + ($urandom % 10)) @(negedge clk);
                sel = int'($urandom % 4);
                a = (sel == 0) ? STAT : (sel == 1) ? IER : 6'h30;
                wr(a, $urandom);
            end
            idle();
            if ($urandom % 2 == 0) rd();
        end

        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule